// File: doc/BRIEF.md
# Memory-Mapped Serial Port with Byte FIFOs

The block is an asynchronous serial port that software drives through a small register window. A single-cycle slave port carries a 12-bit byte address, a write strobe and 32-bit data. Software writes bytes into a transmit FIFO through a data register. It reads received bytes out of a receive FIFO through the same register. A transmit serializer empties the transmit FIFO onto the serial line. A receive deserializer fills the receive FIFO from the incoming line.

Bit timing comes from a programmable divider, and frames can carry an optional even parity bit. One interrupt output is raised from FIFO fill levels. It flags either that the transmit side is running low, or that the receive side has gathered enough bytes. Each of the two conditions has its own threshold register and its own enable bit. The parity error flag clears itself on the next good symbol, so software does not need to clear it.

Top module: `uart_regs`

## Requirements
- R1: After reset the control/status word (offset 0x000) reads 0x0000_0022, the scaler, the transmit threshold and the receive threshold read 0, `ser_tx` is high and `irq` is low.
- R2: The registers are at these offsets. 0x000 is control/status: bit 15 enables parity, bit 14 enables the transmit interrupt and bit 13 enables the receive interrupt, all read/write. Bits 9, 8, 5, 4, 1 and 0 are read-only status, and every other bit reads 0. 0x004 is the scaler, 16 bits. 0x008 is the transmit threshold and 0x00C the receive threshold, 5 bits each, with upper bits reading 0. 0x010 is the data register.
- R3: A transmitted frame is one low start bit, 8 data bits with the LSB first, an even parity bit when bit 15 is set, and a high stop bit. Each bit lasts scaler+1 clock cycles, and the line idles high.
- R4: The transmit FIFO holds 16 bytes. A write to offset 0x010 pushes bits 7:0, and a write while the FIFO is full is dropped. Status bit 0 shows transmit FIFO full and bit 1 shows transmit FIFO empty.
- R5: The receiver re-synchronises on the falling edge of the start bit and samples every bit at its middle. The byte is stored in the receive FIFO even if the frame has an error. A read of offset 0x010 returns the oldest byte in bits 7:0 with bits 31:8 zero, and pops it.
- R6: A read of 0x010 while the receive FIFO is empty returns 0 and changes nothing. A byte that arrives while the receive FIFO (16 bytes) is full is discarded. Status bit 5 shows receive FIFO empty and bit 4 shows receive FIFO full.
- R7: With parity enabled, status bit 8 is set by a received symbol whose parity check fails and cleared by the next symbol whose check passes.
- R8: Status bit 9 is set when a stop bit is sampled low and cleared by the next symbol whose stop bit is sampled high.
- R9: While bit 14 is set, `irq` is high whenever the transmit FIFO holds fewer entries than the transmit threshold.
- R10: While bit 13 is set, `irq` is high whenever the receive FIFO holds at least as many entries as the receive threshold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset in the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| ser_rx | input | 1 | Serial receive line |
| ser_tx | output | 1 | Serial transmit line |
| irq | output | 1 | Level interrupt |

## Verification
Read data is combinational and belongs to the cycle in which the strobe is presented. A read pop or write push takes effect at the closing edge, so the bench samples `bus_rdata` one time unit after it drives the access at a falling clock edge. An idle transmitter drives the start bit two edges after the data write. The monitor therefore re-times on each falling edge of `ser_tx` and samples every bit half a bit period in, while a scoreboard queue supplies the expected bytes. A received byte reaches the FIFO two sync stages after the middle of its stop bit. Each receive check reads status or data only after the driver has also sent two idle bit periods, and the interrupt level is read back in the same settled window.

// File: rtl/uart_pkg.sv
package uart_pkg;
   localparam logic [11:0] A_CTRL  = 12'h000;
   localparam logic [11:0] A_SCALE = 12'h004;
   localparam logic [11:0] A_TXTHR = 12'h008;
   localparam logic [11:0] A_RXTHR = 12'h00C;
   localparam logic [11:0] A_DATA  = 12'h010;

   localparam int B_PAR_EN  = 15;
   localparam int B_TX_IE   = 14;
   localparam int B_RX_IE   = 13;
   localparam int B_STOPERR = 9;
   localparam int B_PARERR  = 8;
   localparam int B_RXEMPTY = 5;
   localparam int B_RXFULL  = 4;
   localparam int B_TXEMPTY = 1;
   localparam int B_TXFULL  = 0;

   typedef enum logic [2:0] {PH_IDLE, PH_START, PH_DATA, PH_PAR, PH_STOP} phase_t;
endpackage

// File: rtl/uart_fifo.sv
module uart_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 16,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [W-1:0]  din,
   input  logic          pop,
   output logic [W-1:0]  dout,
   output logic [CW-1:0] count,
   output logic          full,
   output logic          empty
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("uart_fifo: DEPTH must be a power of two, at least 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic          do_push, do_pop;

   assign full    = (count == CW'(DEPTH));
   assign empty   = (count == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + 1'b1;
         if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
         if (do_push && !do_pop)      count <= count + 1'b1;
         else if (do_pop && !do_push) count <= count - 1'b1;
      end
   end

   p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop) |=> (count == $past(count)));
   p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && empty && !push) |=> (count == '0));
   p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));
endmodule

// File: rtl/uart_tx.sv
module uart_tx
   import uart_pkg::*;
#(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div,
   input  logic             par_en,
   input  logic             have,
   input  logic [7:0]       data,
   output logic             pop,
   output logic             line
);
   phase_t           phase;
   logic [7:0]       sh;
   logic [2:0]       bitn;
   logic [DIV_W-1:0] cnt;
   logic             par_bit, par_l;

   assign pop = (phase == PH_IDLE) && have;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase   <= PH_IDLE;
         line    <= 1'b1;
         sh      <= '0;
         bitn    <= '0;
         cnt     <= '0;
         par_bit <= 1'b0;
         par_l   <= 1'b0;
      end else if (phase == PH_IDLE) begin
         if (have) begin
            sh      <= data;
            par_bit <= ^data;
            par_l   <= par_en;
            cnt     <= div;
            line    <= 1'b0;
            phase   <= PH_START;
         end
      end else if (cnt != '0) begin
         cnt <= cnt - 1'b1;
      end else begin
         cnt <= div;
         case (phase)
            PH_START: begin
               line  <= sh[0];
               sh    <= sh >> 1;
               bitn  <= '0;
               phase <= PH_DATA;
            end
            PH_DATA: begin
               if (bitn == 3'd7) begin
                  line  <= par_l ? par_bit : 1'b1;
                  phase <= par_l ? PH_PAR : PH_STOP;
               end else begin
                  line <= sh[0];
                  sh   <= sh >> 1;
                  bitn <= bitn + 1'b1;
               end
            end
            PH_PAR: begin
               line  <= 1'b1;
               phase <= PH_STOP;
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

   p_idle_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_IDLE) |-> line);
   p_start_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((phase == PH_IDLE) && have) |=> !line);
endmodule

// File: rtl/uart_rx.sv
module uart_rx
   import uart_pkg::*;
#(
   parameter int DIV_W = 16,
   parameter int SYNC  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div,
   input  logic             par_en,
   input  logic             line_in,
   output logic             valid,
   output logic [7:0]       rx_byte,
   output logic             par_used,
   output logic             par_fail,
   output logic             stop_fail
);
   if (SYNC < 2) begin : g_bad_sync
      $error("uart_rx: SYNC must be at least 2");
   end

   logic [SYNC-1:0] sy;
   for (genvar i = 0; i < SYNC; i++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sy[i] <= 1'b1;
         else        sy[i] <= (i == 0) ? line_in : sy[(i == 0) ? 0 : i - 1];
      end
   end

   logic             rxd, prev;
   phase_t           phase;
   logic [2:0]       bitn;
   logic [DIV_W-1:0] cnt;
   logic             pbit;

   assign rxd = sy[SYNC-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev      <= 1'b1;
         phase     <= PH_IDLE;
         bitn      <= '0;
         cnt       <= '0;
         pbit      <= 1'b0;
         rx_byte   <= '0;
         valid     <= 1'b0;
         par_used  <= 1'b0;
         par_fail  <= 1'b0;
         stop_fail <= 1'b0;
      end else begin
         prev  <= rxd;
         valid <= 1'b0;
         if (phase == PH_IDLE) begin
            if (prev && !rxd) begin
               cnt      <= div >> 1;
               par_used <= par_en;
               phase    <= PH_START;
            end
         end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
         end else begin
            cnt <= div;
            case (phase)
               PH_START: begin
                  bitn  <= '0;
                  phase <= rxd ? PH_IDLE : PH_DATA;
               end
               PH_DATA: begin
                  rx_byte <= {rxd, rx_byte[7:1]};
                  bitn    <= bitn + 1'b1;
                  if (bitn == 3'd7) phase <= par_used ? PH_PAR : PH_STOP;
               end
               PH_PAR: begin
                  pbit  <= rxd;
                  phase <= PH_STOP;
               end
               default: begin
                  valid     <= 1'b1;
                  stop_fail <= !rxd;
                  par_fail  <= par_used && ((^rx_byte) ^ pbit);
                  phase     <= PH_IDLE;
               end
            endcase
         end
      end
   end

   p_valid_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      valid |=> !valid);
endmodule

// File: rtl/uart_regs.sv
module uart_regs
   import uart_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int DIV_W = 16,
   parameter int SYNC  = 2,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bus_sel,
   input  logic        bus_wr,
   input  logic [11:0] bus_addr,
   input  logic [31:0] bus_wdata,
   output logic [31:0] bus_rdata,
   input  logic        ser_rx,
   output logic        ser_tx,
   output logic        irq
);
   if (DIV_W < 1 || DIV_W > 32) begin : g_bad_div
      $error("uart_regs: DIV_W must be 1..32");
   end
   if (CW > 32) begin : g_bad_cw
      $error("uart_regs: DEPTH too large for the threshold field");
   end

   logic             ctl_par, ctl_txie, ctl_rxie, err_par, err_stop;
   logic [DIV_W-1:0] scaler;
   logic [CW-1:0]    tx_thr, rx_thr;
   logic             wr_s, rd_s, tx_push, rx_pop;

   assign wr_s    = bus_sel && bus_wr;
   assign rd_s    = bus_sel && !bus_wr;
   assign tx_push = wr_s && (bus_addr == A_DATA);
   assign rx_pop  = rd_s && (bus_addr == A_DATA);

   logic [7:0]    tx_dout, rx_dout, rx_byte;
   logic [CW-1:0] tx_cnt, rx_cnt;
   logic          tx_full, tx_empty, rx_full, rx_empty, tx_pop;
   logic          rx_valid, par_used, par_fail, stop_fail;

   uart_fifo #(.W(8), .DEPTH(DEPTH)) u_txq (
      .clk, .rst_n, .push(tx_push), .din(bus_wdata[7:0]), .pop(tx_pop),
      .dout(tx_dout), .count(tx_cnt), .full(tx_full), .empty(tx_empty));

   uart_fifo #(.W(8), .DEPTH(DEPTH)) u_rxq (
      .clk, .rst_n, .push(rx_valid), .din(rx_byte), .pop(rx_pop),
      .dout(rx_dout), .count(rx_cnt), .full(rx_full), .empty(rx_empty));

   uart_tx #(.DIV_W(DIV_W)) u_tx (
      .clk, .rst_n, .div(scaler), .par_en(ctl_par), .have(!tx_empty),
      .data(tx_dout), .pop(tx_pop), .line(ser_tx));

   uart_rx #(.DIV_W(DIV_W), .SYNC(SYNC)) u_rx (
      .clk, .rst_n, .div(scaler), .par_en(ctl_par), .line_in(ser_rx),
      .valid(rx_valid), .rx_byte(rx_byte), .par_used(par_used),
      .par_fail(par_fail), .stop_fail(stop_fail));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_par  <= 1'b0;
         ctl_txie <= 1'b0;
         ctl_rxie <= 1'b0;
         scaler   <= '0;
         tx_thr   <= '0;
         rx_thr   <= '0;
         err_par  <= 1'b0;
         err_stop <= 1'b0;
      end else begin
         if (wr_s) begin
            case (bus_addr)
               A_CTRL: begin
                  ctl_par  <= bus_wdata[B_PAR_EN];
                  ctl_txie <= bus_wdata[B_TX_IE];
                  ctl_rxie <= bus_wdata[B_RX_IE];
               end
               A_SCALE: scaler <= bus_wdata[DIV_W-1:0];
               A_TXTHR: tx_thr <= bus_wdata[CW-1:0];
               A_RXTHR: rx_thr <= bus_wdata[CW-1:0];
               default: ;
            endcase
         end
         if (rx_valid) begin
            err_stop <= stop_fail;
            if (par_used) err_par <= par_fail;
         end
      end
   end

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         A_CTRL: begin
            bus_rdata[B_PAR_EN]  = ctl_par;
            bus_rdata[B_TX_IE]   = ctl_txie;
            bus_rdata[B_RX_IE]   = ctl_rxie;
            bus_rdata[B_STOPERR] = err_stop;
            bus_rdata[B_PARERR]  = err_par;
            bus_rdata[B_RXEMPTY] = rx_empty;
            bus_rdata[B_RXFULL]  = rx_full;
            bus_rdata[B_TXEMPTY] = tx_empty;
            bus_rdata[B_TXFULL]  = tx_full;
         end
         A_SCALE: bus_rdata[DIV_W-1:0] = scaler;
         A_TXTHR: bus_rdata[CW-1:0]    = tx_thr;
         A_RXTHR: bus_rdata[CW-1:0]    = rx_thr;
         A_DATA:  bus_rdata[7:0]       = rx_empty ? 8'h00 : rx_dout;
         default: ;
      endcase
   end

   assign irq = (ctl_txie && (tx_cnt < tx_thr)) || (ctl_rxie && (rx_cnt >= rx_thr));

   logic unused_wdata;
   assign unused_wdata = ^bus_wdata;

   p_par_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && par_used && !par_fail) |=> !err_par);
   p_stop_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && stop_fail) |=> err_stop);
endmodule

// File: tb/tb_uart_regs.sv
module tb_uart_regs;
   localparam int CLK_P = 10;
   localparam int DIV   = 7;
   localparam int BITC  = DIV + 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        ser_rx = 1'b1;
   logic        ser_tx, irq;

   int nchk = 0, nfail = 0;
   logic [8:0] sb[$];

   always #(CLK_P/2) clk = ~clk;

   uart_regs dut (.clk, .rst_n, .bus_sel, .bus_wr, .bus_addr, .bus_wdata,
                  .bus_rdata, .ser_rx, .ser_tx, .irq);

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
      logic [31:0] d;
      rd(a, d);
      chk(tag, d, exp);
   endtask

   task automatic burst(input int n, input logic [7:0] base, input int nexp, input logic par);
      for (int i = 0; i < nexp; i++) sb.push_back({par, 8'(base + 8'(i))});
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 12'h010; bus_wdata = 32'(base + 8'(i));
      end
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic drain();
      while (sb.size() != 0) @(posedge clk);
      repeat (3*BITC) @(posedge clk);
   endtask

   task automatic rx_frame(input logic [7:0] b, input logic par_on,
                           input logic bad_par, input logic bad_stop);
      @(negedge clk); ser_rx = 1'b0;
      repeat (BITC) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         ser_rx = b[i];
         repeat (BITC) @(negedge clk);
      end
      if (par_on) begin
         ser_rx = (^b) ^ bad_par;
         repeat (BITC) @(negedge clk);
      end
      ser_rx = !bad_stop;
      repeat (BITC) @(negedge clk);
      ser_rx = 1'b1;
      repeat (2*BITC) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   endtask

   // scoreboard monitor on the transmit line
   initial begin
      logic [7:0] b;
      logic [8:0] e;
      logic       s;
      wait (rst_n);
      forever begin
         @(negedge ser_tx);
         repeat (BITC/2) @(posedge clk);
         #1 s = ser_tx;
         chk("R3 start bit", 32'(s), 32'h0);
         for (int i = 0; i < 8; i++) begin
            repeat (BITC) @(posedge clk);
            #1 b[i] = ser_tx;
         end
         if (sb.size() == 0) begin
            chk("R4 unexpected frame", 32'(b), 32'hFFFF_FFFF);
            e = {1'b0, b};
         end else begin
            e = sb.pop_front();
            chk("R3 data byte", 32'(b), 32'(e[7:0]));
         end
         if (e[8]) begin
            repeat (BITC) @(posedge clk);
            #1 chk("R3 parity bit", 32'(ser_tx), 32'(^e[7:0]));
         end
         repeat (BITC) @(posedge clk);
         #1 chk("R3 stop bit", 32'(ser_tx), 32'h1);
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1 reset state
      rd_chk("R1 ctrl", 12'h000, 32'h0000_0022);
      rd_chk("R1 scaler", 12'h004, 32'h0);
      rd_chk("R1 tx thr", 12'h008, 32'h0);
      rd_chk("R1 rx thr", 12'h00C, 32'h0);
      chk("R1 ser_tx", 32'(ser_tx), 32'h1);
      chk("R1 irq", 32'(irq), 32'h0);

      // R2 register map
      wr(12'h004, DIV);
      rd_chk("R2 scaler", 12'h004, DIV);
      wr(12'h008, 32'hFFFF_FFFF);
      rd_chk("R2 tx thr width", 12'h008, 32'h1F);
      wr(12'h008, 0);
      wr(12'h000, 32'hFFFF_FFFF);
      rd_chk("R2 ctrl bits", 12'h000, 32'h0000_E022);
      chk("R10 irq rx thr 0", 32'(irq), 32'h1);
      wr(12'h000, 0);

      // R3 plain frames
      burst(1, 8'h55, 1, 1'b0); drain();
      burst(1, 8'hA3, 1, 1'b0); drain();
      burst(1, 8'h00, 1, 1'b0); drain();
      burst(1, 8'hFF, 1, 1'b0); drain();
      rd_chk("R4 tx empty", 12'h000, 32'h0000_0022);

      // R3 parity frames
      wr(12'h000, 32'h0000_8000);
      burst(1, 8'h01, 1, 1'b1); drain();
      burst(1, 8'h03, 1, 1'b1); drain();
      wr(12'h000, 0);

      // R4 full transmit FIFO: one in the shifter, 16 queued, last dropped
      burst(18, 8'h20, 17, 1'b0);
      rd_chk("R4 tx full", 12'h000, 32'h0000_0021);
      drain();
      chk("R4 tx drained", 32'(sb.size()), 32'h0);

      // R9 transmit threshold interrupt
      wr(12'h000, 32'h0000_4000);
      wr(12'h008, 1);
      chk("R9 irq empty<1", 32'(irq), 32'h1);
      wr(12'h008, 0);
      chk("R9 irq thr 0", 32'(irq), 32'h0);
      wr(12'h008, 2);
      burst(3, 8'h90, 3, 1'b0);
      chk("R9 irq count 2", 32'(irq), 32'h0);
      drain();
      chk("R9 irq after drain", 32'(irq), 32'h1);
      wr(12'h000, 0);
      wr(12'h008, 0);

      // R5 / R6 receive and empty read
      rx_frame(8'h5A, 1'b0, 1'b0, 1'b0);
      rd_chk("R6 rx not empty", 12'h000, 32'h0000_0002);
      rd_chk("R5 rx data", 12'h010, 32'h0000_005A);
      rd_chk("R6 empty read", 12'h010, 32'h0);
      rd_chk("R6 rx empty", 12'h000, 32'h0000_0022);

      // R7 parity error set and self-clear
      wr(12'h000, 32'h0000_8000);
      rx_frame(8'h3C, 1'b1, 1'b1, 1'b0);
      rd_chk("R7 parity err set", 12'h000, 32'h0000_8102);
      rd_chk("R5 byte kept on error", 12'h010, 32'h0000_003C);
      rx_frame(8'h3D, 1'b1, 1'b0, 1'b0);
      rd_chk("R7 parity err clear", 12'h000, 32'h0000_8002);
      rd_chk("R7 good byte", 12'h010, 32'h0000_003D);
      wr(12'h000, 0);

      // R8 stop error
      rx_frame(8'h81, 1'b0, 1'b0, 1'b1);
      rd_chk("R8 stop err set", 12'h000, 32'h0000_0202);
      rx_frame(8'h7E, 1'b0, 1'b0, 1'b0);
      rd_chk("R8 stop err clear", 12'h000, 32'h0000_0002);
      rd_chk("R8 byte a", 12'h010, 32'h0000_0081);
      rd_chk("R8 byte b", 12'h010, 32'h0000_007E);

      // R10 receive threshold interrupt
      wr(12'h00C, 3);
      wr(12'h000, 32'h0000_2000);
      rx_frame(8'h11, 1'b0, 1'b0, 1'b0);
      rx_frame(8'h12, 1'b0, 1'b0, 1'b0);
      chk("R10 irq below thr", 32'(irq), 32'h0);
      rx_frame(8'h13, 1'b0, 1'b0, 1'b0);
      chk("R10 irq at thr", 32'(irq), 32'h1);
      rd(12'h010, d);
      chk("R10 irq after pop", 32'(irq), 32'h0);
      rd(12'h010, d);
      rd(12'h010, d);
      wr(12'h000, 0);
      wr(12'h00C, 0);

      // R6 full receive FIFO drops the 17th byte
      for (int i = 0; i < 17; i++) rx_frame(8'(8'h40 + i), 1'b0, 1'b0, 1'b0);
      rd_chk("R6 rx full", 12'h000, 32'h0000_0012);
      for (int i = 0; i < 16; i++) rd_chk("R6 rx fifo order", 12'h010, 32'(8'h40 + i));
      rd_chk("R6 17th discarded", 12'h010, 32'h0);

      repeat (4*BITC) @(posedge clk);
      finish_run();
   end
endmodule